// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a processor datapath and a 32-bit-wide data memory that is addressed by byte. On each request it adds a sign-extended 16-bit displacement to a base register value to form the effective address. It then issues a word-aligned address to memory. For stores it selects the byte lanes to write and places the store data in those lanes. For loads it raises a read strobe, takes the word the memory returns, picks out the addressed byte, halfword or word, and sign- or zero-extends it to 32 bits.

Lanes are numbered big-endian: byte offset 0 within a word sits in bits 31:24. A request is captured on the clock edge where `req_valid` is high, and the memory-side outputs are registered. The memory returns `mem_rdata` in the cycle after that edge, while `mem_rd` is high. `ld_data` is formed combinationally from `mem_rdata` in that same cycle. The block has no finite-state sequencing. Its only state is one request register that holds the decoded access kind, which is either idle or one of eight access kinds. An access whose address does not match its size raises `acc_err` and touches no memory lane.

Top module: `lsu_lane_align`

## Requirements
- R1: One cycle after a request, `mem_addr` equals `req_base` plus the sign-extended `req_off`, with its two low bits forced to zero.
- R2: A cycle with no request, or a request whose opcode is not one of 0x20, 0x21, 0x23, 0x24, 0x25, 0x28, 0x29 or 0x2b, leaves `mem_be` at 0, `mem_rd` at 0, `acc_err` at 0 and `ld_data` at 0 in the following cycle.
- R3: A byte store (opcode 0x28) at byte offset k (the effective address modulo 4) sets only `mem_be[3-k]`. `mem_wdata` then holds `req_wdata[7:0]` repeated in all four lanes.
- R4: A halfword store (opcode 0x29) at offset 0 gives `mem_be` = 4'b1100, and at offset 2 gives 4'b0011. `mem_wdata` holds `req_wdata[15:0]` in both halves.
- R5: An aligned word store (opcode 0x2b) gives `mem_be` = 4'b1111 and `mem_wdata` = `req_wdata`.
- R6: A halfword access whose address bit 0 is set is misaligned. So is a word access whose address bits 1:0 are not both zero. A misaligned access sets `acc_err`, keeps `mem_be` at 0 and `mem_rd` at 0, and returns `ld_data` = 0.
- R7: A byte load at offset k returns `mem_rdata[31-8k -: 8]`. Opcode 0x20 sign-extends it and opcode 0x24 zero-extends it.
- R8: A halfword load returns `mem_rdata[31:16]` at offset 0 and `mem_rdata[15:0]` at offset 2. Opcode 0x21 sign-extends it and opcode 0x25 zero-extends it.
- R9: An aligned word load (opcode 0x23) returns `mem_rdata` unchanged. Every aligned load raises `mem_rd` and keeps `mem_be` at 0.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 6 | Access opcode |
| req_base | input | 32 | Base register value |
| req_off | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rd | output | 1 | Read strobe for an aligned load |
| mem_rdata | input | 32 | Word returned by memory while mem_rd is high |
| ld_data | output | 32 | Extended load result |
| acc_err | output | 1 | Misaligned access flag |

## Verification
The properties assume that `req_op`, `req_base` and `req_off` are meaningful only at an edge where `req_valid` is high. They also assume that the memory word sits on `mem_rdata` throughout the cycle in which `mem_rd` is high. The stimulus changes every input on the falling clock edge and holds `mem_rdata` steady from the request until the result has been sampled. Directed cases walk each opcode across all four byte offsets, including negative displacements and unknown opcodes. A stream of mixed random requests with idle gaps then follows.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    typedef enum logic [3:0] {
        K_NONE,
        K_LDB_S,
        K_LDB_U,
        K_LDH_S,
        K_LDH_U,
        K_LDW,
        K_STB,
        K_STH,
        K_STW
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_NONE,
        SZ_BYTE,
        SZ_HALF,
        SZ_WORD
    } acc_size_e;

    localparam logic [5:0] OPC_LDB_S = 6'h20;
    localparam logic [5:0] OPC_LDH_S = 6'h21;
    localparam logic [5:0] OPC_LDW   = 6'h23;
    localparam logic [5:0] OPC_LDB_U = 6'h24;
    localparam logic [5:0] OPC_LDH_U = 6'h25;
    localparam logic [5:0] OPC_STB   = 6'h28;
    localparam logic [5:0] OPC_STH   = 6'h29;
    localparam logic [5:0] OPC_STW   = 6'h2b;

    function automatic acc_kind_e decode_op(input logic [5:0] op);
        acc_kind_e k;
        unique case (op)
            OPC_LDB_S: k = K_LDB_S;
            OPC_LDB_U: k = K_LDB_U;
            OPC_LDH_S: k = K_LDH_S;
            OPC_LDH_U: k = K_LDH_U;
            OPC_LDW:   k = K_LDW;
            OPC_STB:   k = K_STB;
            OPC_STH:   k = K_STH;
            OPC_STW:   k = K_STW;
            default:   k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic acc_size_e size_of(input acc_kind_e k);
        acc_size_e s;
        unique case (k)
            K_LDB_S, K_LDB_U, K_STB: s = SZ_BYTE;
            K_LDH_S, K_LDH_U, K_STH: s = SZ_HALF;
            K_LDW, K_STW:            s = SZ_WORD;
            default:                 s = SZ_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_store(input acc_kind_e k);
        return (k == K_STB) || (k == K_STH) || (k == K_STW);
    endfunction

    function automatic logic is_load(input acc_kind_e k);
        return (k == K_LDB_S) || (k == K_LDB_U) || (k == K_LDH_S) ||
               (k == K_LDH_U) || (k == K_LDW);
    endfunction

endpackage

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LANE_W = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    input  acc_size_e         size,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] word_addr,
    output logic              misaligned
);
    localparam int EXT_W = ADDR_W - OFF_W;

    always_comb begin
        ea        = base + {{EXT_W{off[OFF_W-1]}}, off};
        word_addr = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        unique case (size)
            SZ_HALF: misaligned = ea[0];
            SZ_WORD: misaligned = |ea[LANE_W-1:0];
            default: misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  acc_size_e          size,
    input  logic               st_en,
    input  logic [LANE_W-1:0]  lane,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]  wdata_rep
);
    localparam int NUM_LANES = DATA_W / 8;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam logic [LANE_W-1:0] LIDX = LANE_W'(g);
        logic hit;
        always_comb begin
            unique case (size)
                SZ_BYTE: hit = (lane == LIDX);
                SZ_HALF: hit = (lane[LANE_W-1:1] == LIDX[LANE_W-1:1]);
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end
        assign be[NUM_LANES-1-g] = st_en & hit;
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: wdata_rep = {NUM_LANES{wdata[7:0]}};
            SZ_HALF: wdata_rep = {(NUM_LANES/2){wdata[15:0]}};
            default: wdata_rep = wdata;
        endcase
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  acc_kind_e         kind,
    input  logic              ld_en,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    localparam int NUM_LANES = DATA_W / 8;
    localparam int NUM_HALF  = NUM_LANES / 2;

    logic [7:0]  lane_byte [NUM_LANES];
    logic [15:0] lane_half [NUM_HALF];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_byte
        assign lane_byte[g] = rdata[DATA_W-1-8*g -: 8];
    end
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        assign lane_half[h] = rdata[DATA_W-1-16*h -: 16];
    end

    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b = lane_byte[lane];
        sel_h = lane_half[lane[LANE_W-1:1]];
        result = '0;
        if (ld_en) begin
            unique case (kind)
                K_LDB_S: result = {{(DATA_W-8){sel_b[7]}}, sel_b};
                K_LDB_U: result = {{(DATA_W-8){1'b0}}, sel_b};
                K_LDH_S: result = {{(DATA_W-16){sel_h[15]}}, sel_h};
                K_LDH_U: result = {{(DATA_W-16){1'b0}}, sel_h};
                K_LDW:   result = rdata;
                default: result = '0;
            endcase
        end
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16,
    parameter int OP_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] ld_data,
    output logic              acc_err
);
    localparam int NUM_LANES = DATA_W / 8;
    localparam int LANE_W    = $clog2(NUM_LANES);

    acc_kind_e         nx_kind;
    acc_size_e         nx_size;
    logic [ADDR_W-1:0] nx_ea;
    logic [ADDR_W-1:0] nx_waddr;
    logic              nx_mis;
    logic [NUM_LANES-1:0] nx_be;
    logic [DATA_W-1:0] nx_wdata;

    always_comb begin
        nx_kind = decode_op(6'(req_op));
        nx_size = size_of(nx_kind);
    end

    lsu_ea_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_ea (
        .base       (req_base),
        .off        (req_off),
        .size       (nx_size),
        .ea         (nx_ea),
        .word_addr  (nx_waddr),
        .misaligned (nx_mis)
    );

    lsu_store_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_st (
        .size      (nx_size),
        .st_en     (is_store(nx_kind) && !nx_mis),
        .lane      (nx_ea[LANE_W-1:0]),
        .wdata     (req_wdata),
        .be        (nx_be),
        .wdata_rep (nx_wdata)
    );

    acc_kind_e         r_kind;
    logic [LANE_W-1:0] r_lane;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_kind    <= K_NONE;
            r_lane    <= '0;
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
            mem_rd    <= 1'b0;
            acc_err   <= 1'b0;
        end else if (req_valid) begin
            r_kind    <= nx_kind;
            r_lane    <= nx_ea[LANE_W-1:0];
            mem_addr  <= nx_waddr;
            mem_be    <= nx_be;
            mem_wdata <= nx_wdata;
            mem_rd    <= is_load(nx_kind) && !nx_mis;
            acc_err   <= nx_mis;
        end else begin
            r_kind    <= K_NONE;
            mem_be    <= '0;
            mem_rd    <= 1'b0;
            acc_err   <= 1'b0;
        end
    end

    lsu_load_extract #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ld (
        .kind   (r_kind),
        .ld_en  (mem_rd),
        .lane   (r_lane),
        .rdata  (mem_rdata),
        .result (ld_data)
    );
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [5:0]  req_op,
    input logic [31:0] req_base,
    input logic [15:0] req_off,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic        mem_rd,
    input logic        acc_err
);
    logic [31:0] ea_c;
    assign ea_c = req_base + {{16{req_off[15]}}, req_off};

    a_r1_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (mem_addr == ($past(ea_c) & 32'hffff_fffc)));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (mem_be == 4'h0 && !mem_rd && !acc_err));

    a_r3_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mem_be) != 3);

    a_r5_word_store_full: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 6'h2b && ea_c[1:0] == 2'b00) |=> (mem_be == 4'hf));

    a_r6_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (mem_be == 4'h0 && !mem_rd));

    a_r9_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_be == 4'h0));
endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_base  (req_base),
    .req_off   (req_off),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_rd    (mem_rd),
    .acc_err   (acc_err)
);

// File: tb/lsu_lane_align_tb_top.sv
module lsu_lane_align_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        req_valid;
    logic [5:0]  req_op;
    logic [31:0] req_base;
    logic [15:0] req_off;
    logic [31:0] req_wdata;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_rd;
    logic [31:0] mem_rdata;
    logic [31:0] ld_data;
    logic        acc_err;

    lsu_lane_align dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_off(req_off), .req_wdata(req_wdata),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_rdata(mem_rdata), .ld_data(ld_data),
        .acc_err(acc_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    logic [31:0] e_addr, e_wd, e_ld;
    logic [3:0]  e_be;
    logic        e_rd, e_err, e_store;
    string       e_tag;

    task automatic model(input logic [5:0] op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] wd,
                         input logic [31:0] rw);
        logic [31:0] ea, t;
        int size, k, start;
        bit ld, sg;
        ea = base + {{16{off[15]}}, off};
        k = int'(ea[1:0]);
        e_addr = {ea[31:2], 2'b00};
        e_be = 0; e_wd = 0; e_ld = 0; e_rd = 0; e_err = 0; e_store = 0;
        size = 0; ld = 0; sg = 0;
        case (op)
            6'h20: begin size = 1; ld = 1; sg = 1; e_tag = "R7"; end
            6'h24: begin size = 1; ld = 1; e_tag = "R7"; end
            6'h21: begin size = 2; ld = 1; sg = 1; e_tag = "R8"; end
            6'h25: begin size = 2; ld = 1; e_tag = "R8"; end
            6'h23: begin size = 4; ld = 1; e_tag = "R9"; end
            6'h28: begin size = 1; e_tag = "R3"; end
            6'h29: begin size = 2; e_tag = "R4"; end
            6'h2b: begin size = 4; e_tag = "R5"; end
            default: e_tag = "R2";
        endcase
        if (size == 0) return;
        if ((size == 2 && k % 2 != 0) || (size == 4 && k != 0)) begin
            e_err = 1; e_tag = "R6"; return;
        end
        start = k - (k % size);
        if (ld) begin
            e_rd = 1;
            t = rw << (8 * start);
            t = t >> (32 - 8 * size);
            if (sg && t[8*size-1]) t = t | ~((32'h1 << (8 * size)) - 1);
            e_ld = t;
        end else begin
            e_store = 1;
            for (int i = 0; i < 4; i++)
                if (i >= start && i < start + size) e_be[3-i] = 1'b1;
            e_wd = (size == 1) ? {4{wd[7:0]}} : (size == 2) ? {2{wd[15:0]}} : wd;
        end
    endtask

    task automatic do_req(input logic [5:0] op, input logic [31:0] base,
                          input logic [15:0] off, input logic [31:0] wd,
                          input logic [31:0] rw);
        @(negedge clk);
        req_valid = 1; req_op = op; req_base = base; req_off = off;
        req_wdata = wd; mem_rdata = rw;
        model(op, base, off, wd, rw);
        @(negedge clk);
        req_valid = 0;
        chk("R1", "mem_addr", mem_addr, e_addr);
        chk(e_tag, "mem_be", {28'h0, mem_be}, {28'h0, e_be});
        chk(e_tag, "mem_rd", {31'h0, mem_rd}, {31'h0, e_rd});
        chk(e_tag, "acc_err", {31'h0, acc_err}, {31'h0, e_err});
        chk(e_tag, "ld_data", ld_data, e_ld);
        if (e_store) chk(e_tag, "mem_wdata", mem_wdata, e_wd);
    endtask

    task automatic idle_chk();
        @(negedge clk);
        chk("R2", "idle mem_be", {28'h0, mem_be}, 32'h0);
        chk("R2", "idle mem_rd", {31'h0, mem_rd}, 32'h0);
        chk("R2", "idle acc_err", {31'h0, acc_err}, 32'h0);
        chk("R2", "idle ld_data", ld_data, 32'h0);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    localparam logic [5:0] OPS [10] = '{6'h20, 6'h24, 6'h21, 6'h25, 6'h23,
                                         6'h28, 6'h29, 6'h2b, 6'h22, 6'h00};

    initial begin
        rst_n = 0; req_valid = 0; req_op = 0; req_base = 0; req_off = 0;
        req_wdata = 0; mem_rdata = 32'hdead_beef;
        repeat (3) @(negedge clk);
        // R10: outputs are zero while reset is held
        chk("R10", "mem_addr", mem_addr, 0);
        chk("R10", "mem_be", {28'h0, mem_be}, 0);
        chk("R10", "mem_wdata", mem_wdata, 0);
        chk("R10", "mem_rd", {31'h0, mem_rd}, 0);
        chk("R10", "acc_err", {31'h0, acc_err}, 0);
        chk("R10", "ld_data", ld_data, 0);
        rst_n = 1;
        idle_chk();
        // R3 byte store in every lane; R7 byte loads with both extensions
        for (int k = 0; k < 4; k++) begin
            do_req(6'h28, 32'h0000_1000, 16'(k), 32'h1234_56a5, 32'h0);
            do_req(6'h20, 32'h0000_2000, 16'(k), 32'h0, 32'h80f1_7f9c);
            do_req(6'h24, 32'h0000_2000, 16'(k), 32'h0, 32'h80f1_7f9c);
        end
        // R4 / R8 halfword at both aligned offsets
        for (int k = 0; k < 4; k += 2) begin
            do_req(6'h29, 32'h0000_3000, 16'(k), 32'hffff_c3d2, 32'h0);
            do_req(6'h21, 32'h0000_3000, 16'(k), 32'h0, 32'h8001_7ffe);
            do_req(6'h25, 32'h0000_3000, 16'(k), 32'h0, 32'h8001_7ffe);
        end
        // R5 / R9 word access, negative displacement for R1
        do_req(6'h2b, 32'h0000_4010, 16'hfff0, 32'hcafe_f00d, 32'h0);
        do_req(6'h23, 32'h0000_4010, 16'hfffc, 32'h0, 32'h9abc_def0);
        // R6 misaligned halfwords and words
        do_req(6'h29, 32'h0000_5000, 16'd1, 32'h1111_2222, 32'h0);
        do_req(6'h21, 32'h0000_5000, 16'd3, 32'h0, 32'hffff_ffff);
        for (int k = 1; k < 4; k++) begin
            do_req(6'h2b, 32'h0000_6000, 16'(k), 32'h3333_4444, 32'h0);
            do_req(6'h23, 32'h0000_6000, 16'(k), 32'h0, 32'h5555_6666);
        end
        // R2 unknown opcodes and idle cycle
        do_req(6'h22, 32'h0000_7000, 16'd0, 32'h7777_8888, 32'h1234_5678);
        do_req(6'h3f, 32'h0000_7000, 16'd2, 32'h7777_8888, 32'h1234_5678);
        idle_chk();
        // mixed stream
        for (int n = 0; n < 400; n++) begin
            do_req(OPS[$urandom_range(0, 9)], $urandom, 16'($urandom),
                   $urandom, $urandom);
            if (n % 7 == 0) idle_chk();
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule